// File: doc/BRIEF.md
# Last Branch Record Ring

This block keeps a four-deep circular history of the most recently retired taken branches. Every retire strobe that is allowed to record advances a top-of-stack pointer. The source and destination addresses of the branch are then written into the slot the pointer now names, so the pointer always marks the newest pair. Software reads the history, the pointer and a debug control word through a simple indexed register port. Reads are combinational and return data in the same cycle.

The control word decides whether anything is recorded at all. It can also stop recording when a performance-monitor interrupt arrives, or while the system-management-mode input is high. On an interrupt, the same word can request that the performance counters be frozen. The block raises a freeze output for that purpose. A frozen history stays frozen until software writes the control word again.

Top module: `branch_hist_ring`

## Requirements
- R1: After reset, all eight address registers read 0, the top-of-stack register reads 0 and the control word reads 0.
- R2: When a branch is recorded, the pointer first advances by one modulo 4, and the from/to pair is then stored at the new position. The first recorded branch after reset lands in entry 1.
- R3: Register indices: 0x01 is the control word and 0x02 is the pointer, zero-extended. Indices 0x40+i return the source address of entry i, and 0x60+i return the destination address of entry i, for i from 0 to 3. A read returns data in the same cycle as the index.
- R4: Control bit 0 enables recording. While it is 0, retire strobes change neither the pointer nor any entry.
- R5: If control bit 11 is set when `pmi_i` is sampled high, branches from the next cycle on are not recorded. A branch in the same cycle as the interrupt is still recorded.
- R6: When the bit-11 freeze takes effect, control bit 6 (trace-message enable) is cleared.
- R7: If control bit 12 is set when `pmi_i` is sampled high, `perf_freeze_o` goes high from the next cycle. It stays high until the control word is written.
- R8: With `SMM_FREEZE_CAP`=1, control bit 14 set and `smm_i` high, strobes are not recorded. With `SMM_FREEZE_CAP`=0, bit 14 always reads 0 and `smm_i` has no effect.
- R9: A write to the control word stores only bits 0, 6, 11, 12 and 14, with the other bits reading 0. The write clears any freeze and drops `perf_freeze_o`, and it takes priority over an interrupt in the same cycle.
- R10: Reads never change the pointer. Undefined indices read 0. Writes to any index other than 0x01 are ignored, including the pointer and entry registers.
- R11: After four recorded branches the pointer returns to 0. A fifth recorded branch overwrites the oldest entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | Taken-branch retire strobe |
| br_from_i | input | ADDR_W | Branch source address |
| br_to_i | input | ADDR_W | Branch destination address |
| pmi_i | input | 1 | Performance-monitor interrupt pulse |
| smm_i | input | 1 | System-management-mode indicator |
| reg_idx_i | input | 8 | Register index for read and write |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | ADDR_W | Register write data |
| reg_rdata_o | output | ADDR_W | Register read data, combinational |
| perf_freeze_o | output | 1 | Request to freeze performance counters |

## Verification
On every cycle, the assertions check the following:
- the pointer steps modulo 4 when a branch is recorded and holds otherwise;
- the recorded pair lands at the new pointer position;
- the control word keeps only its defined bits;
- after an interrupt with freezing enabled, recording stops, the trace bit drops and the counter-freeze output rises.

Only the bench scenarios can show the rest:
- the register index map and the values read back;
- wrap-around overwrite of the oldest pair;
- that writes to undefined, pointer and entry indices leave state unchanged;
- the difference between the two management-mode capability settings, which the bench shows by driving the same stimulus into both variants.

// File: rtl/branch_hist_pkg.sv
package branch_hist_pkg;
  localparam int unsigned CTL_W        = 16;
  localparam int unsigned BIT_REC_EN   = 0;
  localparam int unsigned BIT_TRACE    = 6;
  localparam int unsigned BIT_FRZ_REC  = 11;
  localparam int unsigned BIT_FRZ_PERF = 12;
  localparam int unsigned BIT_FRZ_SMM  = 14;

  typedef logic [7:0] idx_t;
  localparam idx_t IDX_CTL       = 8'h01;
  localparam idx_t IDX_TOS       = 8'h02;
  localparam idx_t IDX_FROM_BASE = 8'h40;
  localparam idx_t IDX_TO_BASE   = 8'h60;
endpackage

// File: rtl/branch_ctl.sv
module branch_ctl
  import branch_hist_pkg::*;
#(
  parameter bit SMM_FREEZE_CAP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             br_valid_i,
  input  logic             pmi_i,
  input  logic             smm_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             rec_o,
  output logic             perf_freeze_o
);
  localparam logic [CTL_W-1:0] WMASK =
      (CTL_W'(1) << BIT_REC_EN) | (CTL_W'(1) << BIT_TRACE) |
      (CTL_W'(1) << BIT_FRZ_REC) | (CTL_W'(1) << BIT_FRZ_PERF) |
      (SMM_FREEZE_CAP ? (CTL_W'(1) << BIT_FRZ_SMM) : '0);

  logic [CTL_W-1:0] ctl_q;
  logic             frozen_q, pfrz_q;
  logic             smm_block;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q    <= '0;
      frozen_q <= 1'b0;
      pfrz_q   <= 1'b0;
    end else if (ctl_wr_i) begin
      ctl_q    <= ctl_wdata_i & WMASK;
      frozen_q <= 1'b0;
      pfrz_q   <= 1'b0;
    end else if (pmi_i) begin
      if (ctl_q[BIT_FRZ_REC]) begin
        frozen_q         <= 1'b1;
        ctl_q[BIT_TRACE] <= 1'b0;
      end
      if (ctl_q[BIT_FRZ_PERF]) pfrz_q <= 1'b1;
    end
  end

  assign smm_block     = smm_i & ctl_q[BIT_FRZ_SMM];
  assign rec_o         = br_valid_i & ctl_q[BIT_REC_EN] & ~frozen_q & ~smm_block;
  assign ctl_o         = ctl_q;
  assign perf_freeze_o = pfrz_q;

  assert_pmi_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmi_i && ctl_q[BIT_FRZ_REC] && !ctl_wr_i) |=> !rec_o);
  assert_trace_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmi_i && ctl_q[BIT_FRZ_REC] && !ctl_wr_i) |=> !ctl_q[BIT_TRACE]);
  assert_perf_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmi_i && ctl_q[BIT_FRZ_PERF] && !ctl_wr_i) |=> perf_freeze_o);
  assert_write_rearm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i |=> (!perf_freeze_o && ((ctl_q & ~WMASK) == '0)));
endmodule

// File: rtl/branch_store.sv
module branch_store #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rec_i,
  input  logic [ADDR_W-1:0]             from_i,
  input  logic [ADDR_W-1:0]             to_i,
  output logic [$clog2(DEPTH)-1:0]      ptr_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]  from_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]  to_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0]            ptr_q, ptr_nxt;
  logic [DEPTH-1:0][ADDR_W-1:0] from_q, to_q;

  assign ptr_nxt = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (rec_i) ptr_q <= ptr_nxt;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        from_q[g] <= '0;
        to_q[g]   <= '0;
      end else if (rec_i && ptr_nxt == PTR_W'(g)) begin
        from_q[g] <= from_i;
        to_q[g]   <= to_i;
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign from_o = from_q;
  assign to_o   = to_q;

  assert_ptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i |=> (ptr_q == (($past(ptr_q) == PTR_W'(DEPTH - 1)) ? '0 : $past(ptr_q) + 1'b1)));
  assert_pair_written_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i |=> (from_q[ptr_q] == $past(from_i) && to_q[ptr_q] == $past(to_i)));
  assert_ptr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_i |=> $stable(ptr_q));
endmodule

// File: rtl/branch_regmux.sv
module branch_regmux
  import branch_hist_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input  idx_t                          idx_i,
  input  logic [CTL_W-1:0]              ctl_i,
  input  logic [$clog2(DEPTH)-1:0]      ptr_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  from_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  to_i,
  output logic [ADDR_W-1:0]             rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (idx_i == IDX_CTL) rdata_o = ADDR_W'(ctl_i);
    if (idx_i == IDX_TOS) rdata_o = ADDR_W'(ptr_i);
    for (int i = 0; i < DEPTH; i++) begin
      if (idx_i == IDX_FROM_BASE + idx_t'(i)) rdata_o = from_i[i];
      if (idx_i == IDX_TO_BASE + idx_t'(i))   rdata_o = to_i[i];
    end
  end
endmodule

// File: rtl/branch_hist_ring.sv
module branch_hist_ring
  import branch_hist_pkg::*;
#(
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned DEPTH          = 4,
  parameter bit          SMM_FREEZE_CAP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              br_valid_i,
  input  logic [ADDR_W-1:0] br_from_i,
  input  logic [ADDR_W-1:0] br_to_i,
  input  logic              pmi_i,
  input  logic              smm_i,
  input  logic [7:0]        reg_idx_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic              perf_freeze_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic                         ctl_wr, rec;
  logic [CTL_W-1:0]             ctl;
  logic [PTR_W-1:0]             ptr;
  logic [DEPTH-1:0][ADDR_W-1:0] from_arr, to_arr;
  logic                         unused_wdata;

  assign ctl_wr       = reg_wr_i && (reg_idx_i == IDX_CTL);
  assign unused_wdata = ^reg_wdata_i[ADDR_W-1:CTL_W];

  branch_ctl #(.SMM_FREEZE_CAP(SMM_FREEZE_CAP)) u_ctl (
    .clk_i, .rst_ni,
    .ctl_wr_i      (ctl_wr),
    .ctl_wdata_i   (reg_wdata_i[CTL_W-1:0]),
    .br_valid_i,
    .pmi_i,
    .smm_i,
    .ctl_o         (ctl),
    .rec_o         (rec),
    .perf_freeze_o
  );

  branch_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .rec_i  (rec),
    .from_i (br_from_i),
    .to_i   (br_to_i),
    .ptr_o  (ptr),
    .from_o (from_arr),
    .to_o   (to_arr)
  );

  branch_regmux #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_mux (
    .idx_i   (reg_idx_i),
    .ctl_i   (ctl),
    .ptr_i   (ptr),
    .from_i  (from_arr),
    .to_i    (to_arr),
    .rdata_o (reg_rdata_o)
  );

  assert_disabled_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && !ctl[BIT_REC_EN]) |=> $stable(ptr));
  assert_smm_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smm_i && ctl[BIT_FRZ_SMM]) |=> $stable(ptr));
endmodule

// File: tb/branch_hist_ring_tb_top.sv
module branch_hist_ring_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0, pmi = 1'b0, smm = 1'b0, wr = 1'b0;
  logic [31:0] br_from = '0, br_to = '0, wdata = '0;
  logic [7:0]  idx = '0;
  logic [31:0] rdata, rdata2;
  logic        pfrz, pfrz2;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  typedef struct { int sel; logic [31:0] val; string tag; } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  branch_hist_ring dut_i (
    .clk_i(clk), .rst_ni(rst_n), .br_valid_i(br_valid), .br_from_i(br_from),
    .br_to_i(br_to), .pmi_i(pmi), .smm_i(smm), .reg_idx_i(idx), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .perf_freeze_o(pfrz));

  branch_hist_ring #(.SMM_FREEZE_CAP(1'b0)) dut_nosmm_i (
    .clk_i(clk), .rst_ni(rst_n), .br_valid_i(br_valid), .br_from_i(br_from),
    .br_to_i(br_to), .pmi_i(pmi), .smm_i(smm), .reg_idx_i(idx), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata2), .perf_freeze_o(pfrz2));

  // monitor: compare every item queued in this cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = exp_q.pop_front();
      act = (it.sel == 0) ? rdata : (it.sel == 1) ? 32'(pfrz) : rdata2;
      checks++;
      if (act !== it.val) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.val);
      end
    end
  end

  task automatic cyc(input logic w, input logic [7:0] i, input logic [31:0] d,
                     input logic bv, input logic [31:0] f, input logic [31:0] t,
                     input logic p, input logic s);
    @(posedge clk); #1;
    wr = w; idx = i; wdata = d; br_valid = bv; br_from = f; br_to = t; pmi = p; smm = s;
  endtask

  task automatic idle(); cyc(0, 8'h00, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr_reg(input logic [7:0] i, input logic [31:0] d); cyc(1, i, d, 0, 0, 0, 0, 0); endtask
  task automatic branch(input logic [31:0] f, input logic [31:0] t, input logic p, input logic s);
    cyc(0, 8'h00, 0, 1, f, t, p, s);
  endtask
  task automatic rd(input int sel, input logic [7:0] i, input logic [31:0] e, input string tag);
    item_t it;
    cyc(0, i, 0, 0, 0, 0, 0, 0);
    it.sel = sel; it.val = e; it.tag = tag;
    exp_q.push_back(it);
  endtask
  task automatic pf_chk(input logic e, input string tag);
    item_t it;
    idle();
    it.sel = 1; it.val = 32'(e); it.tag = tag;
    exp_q.push_back(it);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(0, 8'h40 + 8'(i), 0, "R1 from reset");
      rd(0, 8'h60 + 8'(i), 0, "R1 to reset");
    end
    rd(0, 8'h02, 0, "R1 tos reset");
    rd(0, 8'h01, 0, "R1 ctl reset");
    // R4 recording disabled
    branch(32'hAAAA_0000, 32'hBBBB_0000, 0, 0);
    rd(0, 8'h02, 0, "R4 tos unchanged");
    rd(0, 8'h41, 0, "R4 entry unchanged");
    // R9 write mask
    wr_reg(8'h01, 32'hFFFF_FFFF);
    rd(0, 8'h01, 32'h0000_5841, "R9 ctl mask");
    rd(2, 8'h01, 32'h0000_1841, "R8 ctl mask no cap");
    // R2 first record lands in entry 1
    branch(32'h0000_1000, 32'h0000_2000, 0, 0);
    rd(0, 8'h02, 1, "R2 tos after first");
    rd(0, 8'h41, 32'h0000_1000, "R3 from[1]");
    rd(0, 8'h61, 32'h0000_2000, "R3 to[1]");
    rd(0, 8'h02, 1, "R10 tos after reads");
    // R11 wrap
    branch(32'h0000_1100, 32'h0000_2100, 0, 0);
    branch(32'h0000_1200, 32'h0000_2200, 0, 0);
    branch(32'h0000_1300, 32'h0000_2300, 0, 0);
    rd(0, 8'h02, 0, "R11 tos wrapped");
    rd(0, 8'h40, 32'h0000_1300, "R11 from[0]");
    rd(0, 8'h63, 32'h0000_2200, "R3 to[3]");
    branch(32'h0000_1400, 32'h0000_2400, 0, 0);
    rd(0, 8'h41, 32'h0000_1400, "R11 oldest overwritten");
    // R8 management mode
    branch(32'h0000_1500, 32'h0000_2500, 0, 1);
    rd(0, 8'h02, 1, "R8 smm blocks record");
    rd(2, 8'h02, 2, "R8 smm ignored no cap");
    // R5 R6 R7 interrupt freeze, branch in same cycle recorded
    branch(32'h0000_1600, 32'h0000_2600, 1, 0);
    pf_chk(1, "R7 perf freeze raised");
    rd(0, 8'h02, 2, "R5 same cycle branch recorded");
    rd(0, 8'h42, 32'h0000_1600, "R5 same cycle entry");
    rd(0, 8'h01, 32'h0000_5801, "R6 trace bit cleared");
    branch(32'h0000_1700, 32'h0000_2700, 0, 0);
    rd(0, 8'h02, 2, "R5 frozen ignores branch");
    pf_chk(1, "R7 perf freeze held");
    // R9 rearm
    wr_reg(8'h01, 32'h0000_0001);
    pf_chk(0, "R9 perf freeze dropped");
    branch(32'h0000_1800, 32'h0000_2800, 0, 0);
    rd(0, 8'h02, 3, "R9 recording rearmed");
    // R10 undefined indices and ignored writes
    rd(0, 8'h44, 0, "R10 undefined 0x44");
    rd(0, 8'h03, 0, "R10 undefined 0x03");
    wr_reg(8'h43, 32'hDEAD_BEEF);
    wr_reg(8'h02, 32'h0000_0001);
    wr_reg(8'h50, 32'h0000_0000);
    rd(0, 8'h43, 32'h0000_1800, "R10 entry write ignored");
    rd(0, 8'h02, 3, "R10 tos write ignored");
    rd(0, 8'h01, 1, "R10 ctl untouched by other writes");
    idle();
    idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule